// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Unit

This unit is the multiply-accumulate datapath that sits beside an integer core's issue stage. Each accepted operation carries two 32-bit operand registers and a handful of control fields. It multiplies either a selected half-word of each operand or the full 32-bit words. The operands are read as signed integers, unsigned integers or signed fractions. The product can be scaled by one bit position in either direction. The result is then added to or subtracted from a 32-bit accumulator, or it is returned as a plain product.

Operations flow through three register stages: operand capture, multiply and accumulate. Half-word operations can be issued every cycle. A full-width multiply makes two passes through a 33x17 multiplier and stalls issue while it does. The accumulate happens in the final stage against the committed accumulator, so dependent back-to-back accumulates need no extra forwarding path.

The accumulator is read and written through a request port. A request waits until every operation in flight has retired, which keeps register access in program order with the arithmetic.

Top module: `mac_pipe`

## Requirements
- R1: A plain half-word multiply accepted at a clock edge shows `res_valid` high with its product on `res` in the third cycle after that edge. A full-width multiply shows it in the fourth cycle.
- R2: Half-word operations are accepted on consecutive cycles. Accepting one never raises `busy`, so only `reg_req` can raise it in the next cycle.
- R3: After a full-width operation is accepted, `busy` is high for the next two cycles. The next operation is accepted at the third edge after it.
- R4: `fmt` = 0 selects signed integers, 1 selects unsigned integers and 2 selects signed fractions (3 behaves like 0). For half-word operations, `x_hi` and `y_hi` select bits 31:16 of the matching operand when 1 and bits 15:0 when 0.
- R5: `shift_sel` = 1 shifts the product left by one bit and 2 shifts it arithmetically right by one bit (rounding toward minus infinity). The values 0 and 3 leave it unshifted. The shift is applied before any accumulate.
- R6: In fractional mode the shifted product is shifted left by one more bit. For full-width operations the upper 32 bits of the resulting 64-bit fraction are kept (Q15 x Q15 gives Q31, Q31 x Q31 gives Q31).
- R7: With `op_acc` = 1 the scaled product is added to the accumulator, or subtracted from it when `op_sub` = 1. A run of back-to-back accumulates gives the same value as the same operations spaced apart.
- R8: With `op_acc` = 0 the scaled product (low 32 bits) is returned on `res` and the accumulator is left unchanged.
- R9: `ovf` is reset to 0. It becomes 1 when an accumulate result leaves the 32-bit range of its format, which is unsigned for `fmt` = 1 and signed otherwise. It stays at 1 until a register write, which clears it.
- R10: While `reg_req` is high, `busy` is high and no operation is accepted. `reg_done` rises only once all accepted operations have retired. At that moment `acc_q` holds the accumulator in program order, and with `reg_we` = 1 the accumulator takes `reg_wdata` at that edge. The accumulator resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_valid | input | 1 | Operation offered; accepted at the edge when busy is low |
| op_acc | input | 1 | 1 accumulate, 0 plain multiply |
| op_wide | input | 1 | 1 full 32x32, 0 half-word 16x16 |
| fmt | input | 2 | Operand format: 0 signed, 1 unsigned, 2 fractional |
| op_sub | input | 1 | Subtract product from accumulator |
| shift_sel | input | 2 | Product scaling: 0 none, 1 left, 2 right |
| x_hi | input | 1 | Upper half-word of opx for half-word operations |
| y_hi | input | 1 | Upper half-word of opy for half-word operations |
| opx | input | 32 | First operand register |
| opy | input | 32 | Second operand register |
| busy | output | 1 | Issue stall |
| res_valid | output | 1 | Plain multiply result valid |
| res | output | 32 | Plain multiply result |
| reg_req | input | 1 | Accumulator access request, held until reg_done |
| reg_we | input | 1 | Access is a write |
| reg_wdata | input | 32 | Accumulator write data |
| reg_done | output | 1 | Access performed this cycle |
| acc_q | output | 32 | Accumulator value |
| ovf | output | 1 | Sticky overflow |

## Verification
The hardest conditions to reach from the ports occur when issue, stall and register access overlap in time. One is an accumulator access requested while a full-width operation is still in its second multiply pass. Another is a half-word accumulate that depends on a result still in flight. The stimulus places a read or write straight after a full-width accumulate, and follows a full-width operation at once with a half-word one so the stall is observed as waiting cycles. Randomised operation streams also overflow the accumulator early and then keep running, which exercises the sticky flag against later in-range results until a write clears it.

// File: rtl/mac_pipe.sv
module mac_pipe #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_valid,
  input  logic          op_acc,
  input  logic          op_wide,
  input  logic [1:0]    fmt,
  input  logic          op_sub,
  input  logic [1:0]    shift_sel,
  input  logic          x_hi,
  input  logic          y_hi,
  input  logic [DW-1:0] opx,
  input  logic [DW-1:0] opy,
  output logic          busy,
  output logic          res_valid,
  output logic [DW-1:0] res,
  input  logic          reg_req,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic          reg_done,
  output logic [DW-1:0] acc_q,
  output logic          ovf
);
  localparam int HW = DW / 2;
  localparam int AW = DW + 1;
  localparam int BW = HW + 1;
  localparam int MW = AW + BW;
  localparam int PW = 2 * DW + 4;
  localparam logic [1:0] F_UNS  = 2'd1;
  localparam logic [1:0] F_FRAC = 2'd2;

  logic                 v1, wide1, acc1, sub1, ph;
  logic [1:0]           fmt1, sh1;
  logic signed [AW-1:0] a1, b1;
  logic                 v2, wide2, acc2, sub2;
  logic [1:0]           fmt2, sh2;
  logic signed [PW-1:0] p2;

  wire iss_ok = issue_valid && !busy;
  wire empty  = !v1 && !v2;
  assign busy     = reg_req || (v1 && wide1);
  assign reg_done = reg_req && empty;

  wire          uns = (fmt == F_UNS);
  wire [HW-1:0] xh  = x_hi ? opx[DW-1:HW] : opx[HW-1:0];
  wire [HW-1:0] yh  = y_hi ? opy[DW-1:HW] : opy[HW-1:0];
  wire signed [AW-1:0] xa = op_wide ? {~uns & opx[DW-1], opx} : {{(AW-HW){~uns & xh[HW-1]}}, xh};
  wire signed [AW-1:0] yb = op_wide ? {~uns & opy[DW-1], opy} : {{(AW-HW){~uns & yh[HW-1]}}, yh};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      v1 <= 1'b0;
      ph <= 1'b0;
      v2 <= 1'b0;
    end else begin
      v1 <= iss_ok || (v1 && wide1 && !ph);
      ph <= v1 && wide1 && !ph;
      v2 <= v1 && (!wide1 || ph);
    end

  always_ff @(posedge clk)
    if (iss_ok) begin
      wide1 <= op_wide;
      acc1  <= op_acc;
      sub1  <= op_sub;
      fmt1  <= fmt;
      sh1   <= shift_sel;
      a1    <= xa;
      b1    <= yb;
    end

  wire signed [BW-1:0] mb = !wide1 ? b1[BW-1:0] : (ph ? b1[AW-1:HW] : {1'b0, b1[HW-1:0]});
  wire signed [MW-1:0] m  = a1 * mb;
  wire signed [PW-1:0] mx = {{(PW-MW){m[MW-1]}}, m};

  always_ff @(posedge clk)
    if (v1) begin
      p2    <= ph ? p2 + (mx <<< HW) : mx;
      wide2 <= wide1;
      acc2  <= acc1;
      sub2  <= sub1;
      fmt2  <= fmt1;
      sh2   <= sh1;
    end

  logic signed [PW-1:0] sp, tm, ae, sum;
  always_comb begin
    case (sh2)
      2'd1:    sp = p2 <<< 1;
      2'd2:    sp = p2 >>> 1;
      default: sp = p2;
    endcase
    tm = sp;
    if (fmt2 == F_FRAC) begin
      tm = sp <<< 1;
      if (wide2) tm = tm >>> DW;
    end
    ae  = (fmt2 == F_UNS) ? {{(PW-DW){1'b0}}, acc_q} : {{(PW-DW){acc_q[DW-1]}}, acc_q};
    sum = sub2 ? ae - tm : ae + tm;
  end

  wire big = (fmt2 == F_UNS) ? |sum[PW-1:DW]
                             : !((&sum[PW-1:DW-1]) || !(|sum[PW-1:DW-1]));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      acc_q     <= '0;
      ovf       <= 1'b0;
      res_valid <= 1'b0;
      res       <= '0;
    end else begin
      res_valid <= v2 && !acc2;
      if (v2 && !acc2) res <= tm[DW-1:0];
      if (reg_done && reg_we) begin
        acc_q <= reg_wdata;
        ovf   <= 1'b0;
      end else if (v2 && acc2) begin
        acc_q <= sum[DW-1:0];
        if (big) ovf <= 1'b1;
      end
    end

  // R1
  mul_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_ok && !op_wide && !op_acc) |=> ##2 res_valid);
  // R1
  wide_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_ok && op_wide && !op_acc) |=> ##3 res_valid);
  // R3
  wide_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_ok && op_wide) |=> busy ##1 busy);
  // R2
  narrow_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_ok && !op_wide) |=> (busy == reg_req));
  // R9
  ovf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_done && reg_we) |=> !ovf);
  // R9
  ovf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(v2 && acc2));
  // R10
  req_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |=> !$rose(v1));
endmodule

// File: tb/mac_pipe_bench.sv
module mac_pipe_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic issue_valid = 0, op_acc = 0, op_wide = 0, op_sub = 0, x_hi = 0, y_hi = 0;
  logic [1:0] fmt = 0, shift_sel = 0;
  logic [31:0] opx = 0, opy = 0, reg_wdata = 0;
  logic reg_req = 0, reg_we = 0;
  logic busy, res_valid, reg_done, ovf;
  logic [31:0] res, acc_q;

  mac_pipe u_mac_pipe (.clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .op_acc(op_acc),
    .op_wide(op_wide), .fmt(fmt), .op_sub(op_sub), .shift_sel(shift_sel), .x_hi(x_hi),
    .y_hi(y_hi), .opx(opx), .opy(opy), .busy(busy), .res_valid(res_valid), .res(res),
    .reg_req(reg_req), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_done(reg_done),
    .acc_q(acc_q), .ovf(ovf));

  always #5 clk = ~clk;

  int nvec = 0, nerr = 0, stalls = 0;
  bit done = 0;
  logic [31:0] m_acc = 0;
  bit m_ovf = 0;
  logic [31:0] expq [0:1023];
  int wr = 0, rd = 0;
  logic [31:0] last_res = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic signed [71:0] ext(input logic [31:0] v, input bit wide, input bit hi, input bit uns);
    logic [15:0] h;
    h = hi ? v[31:16] : v[15:0];
    if (wide) return uns ? {40'd0, v} : {{40{v[31]}}, v};
    return uns ? {56'd0, h} : {{56{h[15]}}, h};
  endfunction

  function automatic logic signed [71:0] term(input bit wide, input logic [1:0] f, input logic [1:0] sh,
      input bit xh, input bit yh, input logic [31:0] x, input logic [31:0] y);
    logic signed [71:0] p;
    p = ext(x, wide, xh, f == 2'd1) * ext(y, wide, yh, f == 2'd1);
    if (sh == 2'd1) p = p <<< 1;
    else if (sh == 2'd2) p = p >>> 1;
    if (f == 2'd2) begin
      p = p <<< 1;
      if (wide) p = p >>> 32;
    end
    return p;
  endfunction

  task automatic do_op(input bit a, input bit w, input logic [1:0] f, input bit s, input logic [1:0] sh,
      input bit xh, input bit yh, input logic [31:0] x, input logic [31:0] y);
    logic signed [71:0] t, ae, sm;
    @(negedge clk);
    op_acc = a; op_wide = w; fmt = f; op_sub = s; shift_sel = sh; x_hi = xh; y_hi = yh;
    opx = x; opy = y; issue_valid = 1;
    #1;
    while (busy) begin stalls++; @(negedge clk); #1; end
    t = term(w, f, sh, xh, yh, x, y);
    if (a) begin
      ae = (f == 2'd1) ? {40'd0, m_acc} : {{40{m_acc[31]}}, m_acc};
      sm = s ? ae - t : ae + t;
      if (f == 2'd1) begin if (sm < 0 || sm > 72'sh0FFFFFFFF) m_ovf = 1; end
      else if (sm < -72'sh080000000 || sm > 72'sh07FFFFFFF) m_ovf = 1;
      m_acc = sm[31:0];
    end else begin
      expq[wr % 1024] = t[31:0];
      wr++;
    end
    @(posedge clk); #1 issue_valid = 0;
  endtask

  always @(negedge clk) if (rst_n && res_valid) begin
    // R8: plain multiply results in program order
    chk(rd != wr && res == expq[rd % 1024], "R8 result", res, expq[rd % 1024]);
    last_res = res;
    rd++;
  end

  task automatic reg_access(input bit we, input logic [31:0] v, input string tag);
    @(negedge clk);
    reg_req = 1; reg_we = we; reg_wdata = v;
    #1;
    chk(busy == 1'b1, "R10 busy during request", busy, 1);
    while (!reg_done) begin @(negedge clk); #1; end
    chk(acc_q == m_acc, tag, acc_q, m_acc);
    chk(ovf == m_ovf, "R9 overflow flag", ovf, m_ovf);
    if (we) begin m_acc = v; m_ovf = 0; end
    @(posedge clk); #1 reg_req = 0; reg_we = 0;
  endtask

  task automatic mul_lit(input bit w, input logic [1:0] f, input logic [1:0] sh, input bit xh, input bit yh,
      input logic [31:0] x, input logic [31:0] y, input logic [31:0] exp, input string tag);
    do_op(0, w, f, 0, sh, xh, yh, x, y);
    while (rd != wr) begin @(negedge clk); #2; end
    chk(last_res == exp, tag, last_res, exp);
  endtask

  task automatic lat_probe(input bit w, input int exp);
    int k;
    k = 0;
    do_op(0, w, 0, 0, 0, 0, 0, 32'd3, 32'd4);
    do begin @(negedge clk); k++; end while (!res_valid && k < 10);
    chk(k == exp, "R1 latency", k, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nvec++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    int s0;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    // R10 and R9: reset state
    chk(acc_q == 0, "R10 reset accumulator", acc_q, 0);
    chk(ovf == 0 && busy == 0 && res_valid == 0, "R9 reset flags", {ovf, busy, res_valid}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    lat_probe(0, 3);
    lat_probe(1, 4);

    // R4
    mul_lit(0, 0, 0, 0, 0, 32'h0000FFFD, 32'h00000005, 32'hFFFFFFF1, "R4 signed half");
    mul_lit(0, 1, 0, 0, 0, 32'h0000FFFF, 32'h0000FFFF, 32'hFFFE0001, "R4 unsigned half");
    mul_lit(0, 0, 0, 1, 1, 32'h00070001, 32'h00060001, 32'd42, "R4 upper halves");
    mul_lit(1, 0, 0, 0, 0, 32'hFFFFFFFF, 32'h00000010, 32'hFFFFFFF0, "R4 signed wide");
    // R5
    mul_lit(0, 0, 1, 0, 0, 32'd7, 32'd3, 32'd42, "R5 left");
    mul_lit(0, 0, 2, 0, 0, 32'd7, 32'd3, 32'd10, "R5 right");
    mul_lit(0, 0, 2, 0, 0, 32'h0000FFF9, 32'd3, 32'hFFFFFFF5, "R5 right negative");
    // R6
    mul_lit(0, 2, 0, 0, 0, 32'h4000, 32'h4000, 32'h20000000, "R6 Q15");
    mul_lit(1, 2, 0, 0, 0, 32'h40000000, 32'h40000000, 32'h20000000, "R6 Q31");

    // R7: back-to-back add/sub
    reg_access(1, 32'd100, "R10 read before write");
    do_op(1, 0, 0, 0, 0, 0, 0, 32'd2, 32'd3);
    do_op(1, 0, 0, 1, 0, 0, 0, 32'd4, 32'd5);
    do_op(1, 0, 0, 0, 0, 0, 0, 32'd1, 32'd1);
    reg_access(0, 0, "R7 chained accumulate");
    chk(m_acc == 32'd87, "R7 expected total", m_acc, 87);

    // R8: plain multiply leaves acc
    mul_lit(0, 0, 0, 0, 0, 32'd9, 32'd9, 32'd81, "R8 product");
    reg_access(0, 0, "R8 accumulator unchanged");

    // R2 / R3: stalls
    s0 = stalls;
    for (int i = 0; i < 4; i++) do_op(1, 0, 0, 0, 0, 0, 0, 32'd1, 32'd2);
    chk(stalls == s0, "R2 no stall", stalls - s0, 0);
    s0 = stalls;
    do_op(1, 1, 0, 0, 0, 0, 0, 32'd5, 32'd6);
    do_op(1, 0, 0, 0, 0, 0, 0, 32'd1, 32'd1);
    chk(stalls - s0 == 2, "R3 wide stall", stalls - s0, 2);
    // R10: read right after wide accumulate
    do_op(1, 1, 0, 0, 0, 0, 0, 32'd1000, 32'd1000);
    reg_access(0, 0, "R10 ordered read");

    // R9: overflow cases
    reg_access(1, 32'h7FFFFFFF, "R9 pre");
    do_op(1, 0, 0, 0, 0, 0, 0, 32'd1, 32'd1);
    do_op(1, 0, 0, 0, 0, 0, 0, 32'd0, 32'd0);
    reg_access(1, 32'hFFFFFFFF, "R9 signed overflow sticky");
    do_op(1, 0, 1, 0, 0, 0, 0, 32'd1, 32'd1);
    reg_access(1, 32'd0, "R9 unsigned overflow");
    do_op(1, 0, 2, 0, 0, 0, 0, 32'h8000, 32'h8000);
    reg_access(0, 0, "R9 fractional overflow");
    chk(m_ovf == 1, "R9 model sticky", m_ovf, 1);
    reg_access(1, 32'd0, "R9 clear");
    reg_access(0, 0, "R9 cleared");

    // random mix
    for (int i = 0; i < 400; i++) begin
      do_op($urandom % 2, ($urandom % 4) == 0, $urandom % 3, $urandom % 2, $urandom % 4,
            $urandom % 2, $urandom % 2, $urandom, $urandom);
      if (i % 25 == 24) reg_access(($urandom % 3) == 0, $urandom, "R7 random accumulate");
    end
    reg_access(0, 0, "R7 final");
    repeat (6) @(negedge clk);
    chk(rd == wr, "R8 all results seen", rd, wr);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule